// File: doc/BRIEF.md
# Camera Frame Capture Controller

This block takes an 8-bit camera byte stream, framed by a start-of-frame pulse and an end-of-frame pulse, and turns it into a sequence of 32-bit memory write requests. Each request carries an address, data and byte strobes. Software controls it through a small word-addressed register file. That register file holds a pipe enable, a capture request, a destination base address, an optional size limit in words, a byte count for the last frame, a capture-active status, and event enable, flag and clear registers.

The destination base is a shadow copy. The value software writes is moved into the working base only when a start-of-frame pulse arrives, so software can reprogram the next buffer while the current frame is still being written. When software clears the capture request in the middle of a frame, that frame still completes, and no later frame is captured. An optional word limit protects the buffer: bytes beyond the limit are dropped and an overrun event is raised. The interrupt output is the OR of the event flags whose enables are set.

Top module: `frame_capture_ctrl`

## Requirements
- R1: After reset, every register reads as zero, including byte count (offset 4), status (offset 5) and event flags (offset 7). After reset, `irq` and `mem_wr_valid` are low.
- R2: A `pix_vsync` pulse starts capture when two conditions hold: pipe enable (offset 0, bit 31) is 1, and capture request (offset 1, bit 0) is 1. Status bit 0 (offset 5) then reads 1. With pipe enable at 0, no writes are issued and no events are flagged.
- R3: Two rules apply to the destination register (offset 2). First, bits 3:0 are forced to zero on write. Second, a written value moves into the working base only at the next `pix_vsync`; a write made mid-frame does not affect the frame in progress.
- R4: Accepted bytes are packed little-endian: byte k of a word lands in bits 8k+7:8k. A full word is written with strobe 4'hF at base + 4 × (word index within the frame).
- R5: At `pix_frame_end`, a partly filled word is flushed. Its address is the next word slot and its strobe covers only the filled low lanes (4'h1, 4'h3 or 4'h7).
- R6: The byte count (offset 4) reports the bytes accepted in the current or last frame. It holds after frame end and returns to zero at each `pix_vsync` while the pipe is enabled. A `pix_vsync` arriving mid-frame discards the partial word.
- R7: Clearing the capture request mid-frame lets that frame finish. Status drops at its `pix_frame_end`, and later `pix_vsync` pulses start no capture.
- R8: The size limit register (offset 3) has an enable in bit 31 and a word count in bits 23:0. When the limit is enabled, bytes beyond 4 × limit in a frame are dropped, the byte count stops at 4 × limit, and the overrun flag (bit 15) is set.
- R9: Event flags at offset 7 are sticky and sit at fixed bits: end-of-frame at bit 9, start-of-frame at bit 10, overrun at bit 15. Every `pix_vsync` with the pipe enabled sets bit 10, even with no frame end before it. Bit 9 is set only when a capturing frame ends.
- R10: Writing 1 to a bit of the clear register (offset 8) clears that flag. `irq` is high exactly when some flag is set whose enable (offset 6, same bit positions) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| pix_vsync | input | 1 | Start-of-frame pulse |
| pix_frame_end | input | 1 | End-of-frame pulse |
| pix_valid | input | 1 | Pixel byte valid |
| pix_data | input | 8 | Pixel byte |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_addr | output | 32 | Write byte address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_strb | output | 4 | Byte lane strobes |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes the destination register mid-frame and confirms the frame in progress keeps its old base. A design that loaded the address at once would split a frame across two buffers. It clears the capture request mid-frame and checks that the remaining words still arrive and that status drops only at frame end. An early stop would truncate the frame, and a late stop would capture one frame too many. It sends bytes past an enabled word limit, with no partial word left over, and sends back-to-back start pulses. Together these expose an off-by-one in the limit compare, a missing overrun flag, and a stale partial word that survives a restart and gets written later.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    localparam logic [3:0] OFS_PIPE  = 4'h0;
    localparam logic [3:0] OFS_CAPT  = 4'h1;
    localparam logic [3:0] OFS_DEST  = 4'h2;
    localparam logic [3:0] OFS_LIMIT = 4'h3;
    localparam logic [3:0] OFS_COUNT = 4'h4;
    localparam logic [3:0] OFS_STAT  = 4'h5;
    localparam logic [3:0] OFS_IEN   = 4'h6;
    localparam logic [3:0] OFS_FLAG  = 4'h7;
    localparam logic [3:0] OFS_FCLR  = 4'h8;

    localparam int BIT_FEND  = 9;
    localparam int BIT_VSYNC = 10;
    localparam int BIT_OVR   = 15;
    localparam int BIT_EN    = 31;

    typedef struct packed {
        logic fend;
        logic vsync;
        logic ovr;
    } evt_t;
endpackage

// File: rtl/fcc_regs.sv
module fcc_regs
    import fcc_pkg::*;
#(
    parameter int LIMIT_W    = 24,
    parameter int ALIGN_BITS = 4,
    localparam int CNT_W     = LIMIT_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  evt_t               evt,
    input  logic               active,
    input  logic [CNT_W-1:0]   byte_cnt,
    output logic               pipe_en,
    output logic               cap_req,
    output logic [31:0]        dest,
    output logic               lim_en,
    output logic [LIMIT_W-1:0] lim,
    output logic               irq
);
    typedef struct packed {
        logic               pipe_en;
        logic               cap_req;
        logic [31:0]        dest;
        logic               lim_en;
        logic [LIMIT_W-1:0] lim;
        evt_t               ien;
        evt_t               flg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                OFS_PIPE:  r_d.pipe_en = wdata[BIT_EN];
                OFS_CAPT:  r_d.cap_req = wdata[0];
                OFS_DEST:  r_d.dest    = {wdata[31:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                OFS_LIMIT: begin
                    r_d.lim_en = wdata[BIT_EN];
                    r_d.lim    = wdata[LIMIT_W-1:0];
                end
                OFS_IEN: begin
                    r_d.ien.fend  = wdata[BIT_FEND];
                    r_d.ien.vsync = wdata[BIT_VSYNC];
                    r_d.ien.ovr   = wdata[BIT_OVR];
                end
                OFS_FCLR: begin
                    if (wdata[BIT_FEND])  r_d.flg.fend  = 1'b0;
                    if (wdata[BIT_VSYNC]) r_d.flg.vsync = 1'b0;
                    if (wdata[BIT_OVR])   r_d.flg.ovr   = 1'b0;
                end
                default: ;
            endcase
        end
        r_d.flg = r_d.flg | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_PIPE:  rdata[BIT_EN] = r_q.pipe_en;
            OFS_CAPT:  rdata[0] = r_q.cap_req;
            OFS_DEST:  rdata = r_q.dest;
            OFS_LIMIT: begin
                rdata[BIT_EN] = r_q.lim_en;
                rdata[LIMIT_W-1:0] = r_q.lim;
            end
            OFS_COUNT: rdata = 32'(byte_cnt);
            OFS_STAT:  rdata[0] = active;
            OFS_IEN: begin
                rdata[BIT_FEND]  = r_q.ien.fend;
                rdata[BIT_VSYNC] = r_q.ien.vsync;
                rdata[BIT_OVR]   = r_q.ien.ovr;
            end
            OFS_FLAG: begin
                rdata[BIT_FEND]  = r_q.flg.fend;
                rdata[BIT_VSYNC] = r_q.flg.vsync;
                rdata[BIT_OVR]   = r_q.flg.ovr;
            end
            default: ;
        endcase
    end

    assign pipe_en = r_q.pipe_en;
    assign cap_req = r_q.cap_req;
    assign dest    = r_q.dest;
    assign lim_en  = r_q.lim_en;
    assign lim     = r_q.lim;
    assign irq     = |(r_q.flg & r_q.ien);
endmodule

// File: rtl/fcc_framer.sv
module fcc_framer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vsync,
    input  logic        frame_end,
    input  logic        pipe_en,
    input  logic        cap_req,
    input  logic [31:0] dest,
    output logic        active,
    output logic [31:0] base,
    output logic        evt_vsync,
    output logic        evt_fend
);
    typedef struct packed {
        logic        active;
        logic [31:0] base;
    } frm_t;

    frm_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        evt_vsync = pipe_en && vsync;
        evt_fend  = pipe_en && frame_end && !vsync && f_q.active;
        if (!pipe_en) begin
            f_d.active = 1'b0;
        end else if (vsync) begin
            f_d.active = cap_req;
            f_d.base   = dest;
        end else if (frame_end) begin
            f_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign active = f_q.active;
    assign base   = f_q.base;
endmodule

// File: rtl/fcc_packer.sv
module fcc_packer #(
    parameter int LIMIT_W = 24,
    localparam int CNT_W  = LIMIT_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               active,
    input  logic               byte_vld,
    input  logic [7:0]         byte_dat,
    input  logic               frame_end,
    input  logic [31:0]        base,
    input  logic               lim_en,
    input  logic [LIMIT_W-1:0] lim,
    output logic               wr_vld,
    output logic [31:0]        wr_addr,
    output logic [31:0]        wr_data,
    output logic [3:0]         wr_strb,
    output logic [CNT_W-1:0]   byte_cnt,
    output logic               ovr_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [31:0]      word;
        logic             wr_vld;
        logic [31:0]      wr_addr;
        logic [31:0]      wr_data;
        logic [3:0]       wr_strb;
    } pk_t;

    pk_t p_d, p_q;
    logic [1:0]  lane;
    logic [1:0]  rem;
    logic        full;
    logic        take;
    logic [31:0] word_n;

    always_comb begin
        p_d        = p_q;
        p_d.wr_vld = 1'b0;
        lane       = p_q.cnt[1:0];
        full       = lim_en && (p_q.cnt >= {lim, 2'b00});
        take       = active && byte_vld && !restart && !full;
        ovr_evt    = active && byte_vld && !restart && full;
        word_n     = p_q.word;
        word_n[{lane, 3'b000} +: 8] = byte_dat;
        rem        = 2'd0;
        if (restart) begin
            p_d.cnt  = '0;
            p_d.word = '0;
        end else begin
            if (take) begin
                p_d.cnt  = p_q.cnt + 1'b1;
                p_d.word = word_n;
                if (lane == 2'd3) begin
                    p_d.wr_vld  = 1'b1;
                    p_d.wr_addr = base + 32'({p_q.cnt[CNT_W-1:2], 2'b00});
                    p_d.wr_data = word_n;
                    p_d.wr_strb = 4'hF;
                    p_d.word    = '0;
                end
            end
            rem = p_d.cnt[1:0];
            if (frame_end && active && rem != 2'd0) begin
                p_d.wr_vld  = 1'b1;
                p_d.wr_addr = base + 32'({p_d.cnt[CNT_W-1:2], 2'b00});
                p_d.wr_data = p_d.word;
                case (rem)
                    2'd1:    p_d.wr_strb = 4'h1;
                    2'd2:    p_d.wr_strb = 4'h3;
                    default: p_d.wr_strb = 4'h7;
                endcase
                p_d.word = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign wr_vld   = p_q.wr_vld;
    assign wr_addr  = p_q.wr_addr;
    assign wr_data  = p_q.wr_data;
    assign wr_strb  = p_q.wr_strb;
    assign byte_cnt = p_q.cnt;
endmodule

// File: rtl/frame_capture_ctrl.sv
module frame_capture_ctrl
    import fcc_pkg::*;
#(
    parameter int LIMIT_W    = 24,
    parameter int ALIGN_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        pix_vsync,
    input  logic        pix_frame_end,
    input  logic        pix_valid,
    input  logic [7:0]  pix_data,
    output logic        mem_wr_valid,
    output logic [31:0] mem_wr_addr,
    output logic [31:0] mem_wr_data,
    output logic [3:0]  mem_wr_strb,
    output logic        irq
);
    localparam int CNT_W = LIMIT_W + 2;

    logic               pipe_en, cap_req, lim_en, active;
    logic [31:0]        dest, base;
    logic [LIMIT_W-1:0] lim_words;
    logic [CNT_W-1:0]   byte_cnt;
    logic               evt_vsync, evt_fend, evt_ovr;
    evt_t               evt;

    assign evt = '{fend: evt_fend, vsync: evt_vsync, ovr: evt_ovr};

    fcc_regs #(.LIMIT_W(LIMIT_W), .ALIGN_BITS(ALIGN_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .evt(evt), .active(active),
        .byte_cnt(byte_cnt), .pipe_en(pipe_en), .cap_req(cap_req),
        .dest(dest), .lim_en(lim_en), .lim(lim_words), .irq(irq)
    );

    fcc_framer u_framer (
        .clk(clk), .rst_n(rst_n), .vsync(pix_vsync), .frame_end(pix_frame_end),
        .pipe_en(pipe_en), .cap_req(cap_req), .dest(dest), .active(active),
        .base(base), .evt_vsync(evt_vsync), .evt_fend(evt_fend)
    );

    fcc_packer #(.LIMIT_W(LIMIT_W)) u_packer (
        .clk(clk), .rst_n(rst_n), .restart(evt_vsync), .active(active),
        .byte_vld(pix_valid), .byte_dat(pix_data), .frame_end(pix_frame_end),
        .base(base), .lim_en(lim_en), .lim(lim_words),
        .wr_vld(mem_wr_valid), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
        .wr_strb(mem_wr_strb), .byte_cnt(byte_cnt), .ovr_evt(evt_ovr)
    );
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
    parameter int LIMIT_W = 24,
    localparam int CNT_W  = LIMIT_W + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vsync,
    input logic               frame_end,
    input logic               pipe_en,
    input logic               cap_req,
    input logic               active,
    input logic               mem_wr_valid,
    input logic [31:0]        mem_wr_addr,
    input logic [3:0]         mem_wr_strb,
    input logic               lim_en,
    input logic [LIMIT_W-1:0] lim,
    input logic [CNT_W-1:0]   byte_cnt
);
    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_en && cap_req && vsync |=> active);
    // R7
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(frame_end || vsync || !pipe_en));
    // R2
    write_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> $past(active));
    // R4
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> mem_wr_addr[1:0] == 2'b00);
    // R5
    strb_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (mem_wr_strb == 4'h1 || mem_wr_strb == 4'h3 ||
                          mem_wr_strb == 4'h7 || mem_wr_strb == 4'hF));
    // R8
    limit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cnt > $past(byte_cnt)) && $past(lim_en) |-> byte_cnt <= {$past(lim), 2'b00});
endmodule

bind frame_capture_ctrl fcc_checker #(.LIMIT_W(LIMIT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .vsync(pix_vsync), .frame_end(pix_frame_end),
    .pipe_en(pipe_en), .cap_req(cap_req), .active(active),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_strb(mem_wr_strb),
    .lim_en(lim_en), .lim(lim_words), .byte_cnt(byte_cnt)
);

// File: tb/frame_capture_ctrl_tb.sv
`timescale 1ns/1ps
module frame_capture_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_vsync = 1'b0, pix_frame_end = 1'b0, pix_valid = 1'b0;
    logic [7:0]  pix_data = '0;
    logic        mem_wr_valid;
    logic [31:0] mem_wr_addr, mem_wr_data;
    logic [3:0]  mem_wr_strb;
    logic        irq;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
    } item_t;

    item_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;

    // bench-side model state
    bit          m_pipe, m_req, m_active, m_lim_en;
    logic [31:0] m_dest, m_base, m_word;
    int          m_cnt, m_lim;

    always #5 clk = ~clk;

    frame_capture_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_vsync(pix_vsync),
        .pix_frame_end(pix_frame_end), .pix_valid(pix_valid), .pix_data(pix_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_strb(mem_wr_strb), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops scoreboard on every write
    always @(negedge clk) begin
        if (rst_n && mem_wr_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R7 unexpected write", mem_wr_addr, 32'h0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(mem_wr_addr == e.addr, "R3/R4 write address", mem_wr_addr, e.addr);
                check(mem_wr_data == e.data, "R4 write data", mem_wr_data, e.data);
                check(mem_wr_strb == e.strb, "R5 write strobe", {28'h0, mem_wr_strb}, {28'h0, e.strb});
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (a == 4'h0) m_pipe = d[31];
        if (a == 4'h1) m_req = d[0];
        if (a == 4'h2) m_dest = {d[31:4], 4'h0};
        if (a == 4'h3) begin m_lim_en = d[31]; m_lim = int'(d[23:0]); end
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic vsync();
        @(negedge clk);
        pix_vsync = 1'b1;
        if (m_pipe) begin
            m_active = m_req; m_base = m_dest; m_cnt = 0; m_word = '0;
        end
        @(negedge clk);
        pix_vsync = 1'b0;
    endtask

    task automatic frame_end();
        @(negedge clk);
        pix_frame_end = 1'b1;
        if (m_active && m_pipe && (m_cnt % 4) != 0) begin
            item_t e;
            e.addr = m_base + 32'((m_cnt / 4) * 4);
            e.data = m_word;
            e.strb = (m_cnt % 4 == 1) ? 4'h1 : (m_cnt % 4 == 2) ? 4'h3 : 4'h7;
            exp_q.push_back(e);
        end
        m_active = 0; m_word = '0;
        @(negedge clk);
        pix_frame_end = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        pix_valid = 1'b1; pix_data = b;
        if (m_active && m_pipe && (!m_lim_en || m_cnt < 4 * m_lim)) begin
            m_word[(m_cnt % 4) * 8 +: 8] = b;
            if (m_cnt % 4 == 3) begin
                item_t e;
                e.addr = m_base + 32'((m_cnt / 4) * 4);
                e.data = m_word; e.strb = 4'hF;
                exp_q.push_back(e);
                m_word = '0;
            end
            m_cnt++;
        end
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        check(1'b0, "watchdog", 32'h0, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'h4, 32'h0, "R1 count after reset");
        rd(4'h5, 32'h0, "R1 status after reset");
        rd(4'h7, 32'h0, "R1 flags after reset");
        check(irq == 1'b0 && mem_wr_valid == 1'b0, "R1 irq/valid after reset", {31'h0, irq}, 32'h0);

        // R2 pipe disabled: nothing happens
        wr(4'h1, 32'h1);
        wr(4'h6, 32'h0000_8600);
        vsync();
        for (int i = 0; i < 4; i++) send(8'hE0 + 8'(i));
        rd(4'h5, 32'h0, "R2 no capture with pipe off");
        rd(4'h7, 32'h0, "R2 no events with pipe off");

        // R3 alignment, R2 start
        wr(4'h0, 32'h8000_0000);
        wr(4'h2, 32'h1000_0007);
        rd(4'h2, 32'h1000_0000, "R3 low bits forced zero");
        vsync();
        rd(4'h5, 32'h1, "R2 status active");
        rd(4'h7, 32'h0000_0400, "R9 vsync flag");
        check(irq == 1'b1, "R10 irq from enabled flag", {31'h0, irq}, 32'h1);
        wr(4'h8, 32'h0000_0400);
        rd(4'h7, 32'h0, "R10 flag cleared");
        check(irq == 1'b0, "R10 irq low after clear", {31'h0, irq}, 32'h0);

        // R4 packing, R3 shadow mid-frame, R5 partial flush
        for (int i = 0; i < 4; i++) send(8'h11 * 8'(i + 1));
        wr(4'h2, 32'h2000_0000);
        for (int i = 4; i < 10; i++) send(8'h11 * 8'(i + 1));
        frame_end();
        rd(4'h4, 32'd10, "R6 byte count held after frame end");
        rd(4'h5, 32'h0, "R7 status drops at frame end");
        rd(4'h7, 32'h0000_0200, "R9 frame-end flag");
        wr(4'h8, 32'h0000_8600);

        // R6 count reset, R3 new base used
        vsync();
        rd(4'h4, 32'h0, "R6 count reset at vsync");
        for (int i = 0; i < 4; i++) send(8'hA0 + 8'(i));
        // R7 clear request mid-frame
        wr(4'h1, 32'h0);
        rd(4'h5, 32'h1, "R7 still active after request cleared");
        for (int i = 0; i < 4; i++) send(8'hB0 + 8'(i));
        frame_end();
        rd(4'h5, 32'h0, "R7 inactive after frame end");
        vsync();
        for (int i = 0; i < 4; i++) send(8'hC0 + 8'(i));
        rd(4'h5, 32'h0, "R7 no new capture");
        rd(4'h4, 32'h0, "R7 no bytes accepted");

        // R8 limit of 2 words
        wr(4'h3, 32'h8000_0002);
        wr(4'h1, 32'h1);
        wr(4'h8, 32'h0000_8600);
        vsync();
        for (int i = 0; i < 11; i++) send(8'h30 + 8'(i));
        rd(4'h4, 32'd8, "R8 count stops at limit");
        rd(4'h7, 32'h0000_8400, "R8 overrun flag");
        frame_end();
        wr(4'h3, 32'h0);
        wr(4'h8, 32'h0000_8600);

        // R9/R6 vsync without frame end discards partial word
        vsync();
        send(8'h55); send(8'h66);
        vsync();
        for (int i = 0; i < 4; i++) send(8'h70 + 8'(i));
        rd(4'h4, 32'd4, "R6 restart on vsync without frame end");
        rd(4'h7, 32'h0000_0400, "R9 vsync flag without frame end");
        frame_end();

        // R10 masking: flags set but enables off
        wr(4'h6, 32'h0);
        wr(4'h8, 32'h0000_8600);
        vsync();
        rd(4'h7, 32'h0000_0400, "R10 flag set while masked");
        check(irq == 1'b0, "R10 irq masked", {31'h0, irq}, 32'h0);
        frame_end();

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R4 all expected writes seen", 32'(exp_q.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule